// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one IEEE-754 operand, binary32 or binary64, into a 32-bit or 64-bit integer, signed or unsigned. Rounding is either round-to-nearest with ties to even or truncation toward zero. Two status flags come back with each result: invalid and inexact. A caller places the operand, sets the four mode selects and pulses the input strobe for one cycle. The result and flags appear, registered, on the next clock edge together with an output strobe.

Any input that cannot be represented is clamped rather than wrapped. An unsigned target rejects every negative nonzero input before rounding is considered. This includes a tiny negative value that would round to zero. A NaN gives all ones at the selected width, for signed and unsigned targets alike, so a signed target reads -1. Infinities and out-of-range finite values clamp to the nearest end of the target range.

Top module: `fp_to_int_conv`

## Requirements
- R1: The result and flags are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Without a strobe, `out_result` and `out_flags` hold their previous values.
- R2: With `in_trunc` low, an in-range value rounds to the nearest integer, and a tie goes to the even integer (2.5 gives 2, 3.5 gives 4, -2.5 gives -2, 0.5 gives 0).
- R3: With `in_trunc` high, an in-range value is rounded toward zero (0.75 gives 0, -2.5 gives -2).
- R4: Inexact is `out_flags[5]`. It is set when an in-range conversion discarded nonzero fraction bits, including a denormal input. Invalid and inexact are never set together.
- R5: For an unsigned target, any negative nonzero input gives 0 and sets invalid (`out_flags[1]`) in both rounding modes and at both widths. Negative zero gives 0 with no flag.
- R6: A NaN input, from either source precision and in either rounding mode, gives all ones at the selected width and sets invalid, for signed and unsigned targets.
- R7: Infinities and finite values beyond the target range clamp to the maximum (positive side) or minimum (negative side, signed only) and set invalid. The exact endpoints, such as -2^63 to signed 64-bit, convert without a flag.
- R8: With a 32-bit target, `out_result[63:32]` is zero. Flag bits 0, 2, 3 and 4 are always zero.
- R9: A binary32 operand is taken from `in_operand[31:0]` when `in_is_double` is low. `in_operand[63:32]` is ignored in that case.
- R10: After synchronous reset, `out_valid`, `out_result` and `out_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Floating-point operand (binary32 in bits 31:0) |
| in_is_double | input | 1 | 1: binary64 source, 0: binary32 source |
| in_dst_64 | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_signed | input | 1 | 1: signed target, 0: unsigned target |
| in_trunc | input | 1 | 1: round toward zero, 0: nearest-even |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | Integer result, zero-extended for 32-bit targets |
| out_flags | output | 6 | Status: bit 1 invalid, bit 5 inexact |

## Verification
Random operands are built as an integer part plus a quarter fraction, with a random sign. Because the quarter fraction can be 0, 1/4, 1/2 or 3/4, every draw lands in one of four cases: exact, round-down, tie or round-up. Ties separate odd and even integer parts, which exposes a rounding step that ignores evenness. Integer parts are sized so that some draws exceed 32-bit ranges, which separates clamping from wrap-around. Directed operands cover the cases that random draws rarely reach: NaNs of both kinds, infinities, the exact range endpoints, negative zero, tiny negatives and denormals, and non-zero upper bits under a binary32 source.

// File: rtl/fpi_pkg.sv
// Package: shared constants and types for the float-to-integer converter.
// Assumes IEEE-754 binary32/binary64 field layouts.
package fpi_pkg;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int OPND_W     = 1 + DBL_EXP_W + DBL_FRAC_W;
    localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int SIG_W      = DBL_FRAC_W + 1;
    localparam int EXP_W      = DBL_EXP_W + 2;
    localparam int INT_W      = 64;
    localparam int NARROW_W   = 32;
    localparam int FIX_W      = 2 * INT_W;
    localparam int FLAG_W     = 6;
    localparam int INV_BIT    = 1;
    localparam int INEX_BIT   = 5;

    // Decoded operand: value = sig * 2^(exp - (SIG_W-1)) when finite.
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_inf;
        logic             is_zero;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } fp_unpacked_t;
endpackage

// File: rtl/fpi_decode.sv
// Module: splits one IEEE-754 format into class, unbiased exponent and a
// left-aligned significand. Assumes EW+2 <= EXP_W and FW < SIG_W.
module fpi_decode
    import fpi_pkg::*;
#(
    parameter int EW = 11,
    parameter int FW = 52
) (
    input  logic [EW+FW:0]  bits_i,
    output fp_unpacked_t    dec_o
);
    localparam int BIAS  = (1 << (EW - 1)) - 1;
    localparam int ALIGN = SIG_W - 1 - FW;

    logic [EW-1:0]    fld_exp;
    logic [FW-1:0]    fld_frac;
    logic             exp_max;
    logic             exp_min;
    logic [SIG_W-1:0] raw_sig;

    assign fld_exp  = bits_i[EW+FW-1:FW];
    assign fld_frac = bits_i[FW-1:0];
    assign exp_max  = &fld_exp;
    assign exp_min  = ~|fld_exp;

    // Classify the operand and rebuild its significand.
    always_comb begin
        dec_o.sign    = bits_i[EW+FW];
        dec_o.is_nan  = exp_max && (fld_frac != '0);
        dec_o.is_inf  = exp_max && (fld_frac == '0);
        dec_o.is_zero = exp_min && (fld_frac == '0);
        raw_sig       = SIG_W'({~exp_min, fld_frac});
        dec_o.sig     = raw_sig << ALIGN;
        if (exp_min)
            dec_o.exp = EXP_W'(1 - BIAS);
        else
            dec_o.exp = EXP_W'(fld_exp) - EXP_W'(BIAS);
    end
endmodule

// File: rtl/fpi_align_round.sv
// Module: shifts the significand to a fixed point with INT_W integer and
// INT_W fraction bits, then rounds (nearest-even or toward zero).
// Assumes finite input; special classes are resolved downstream.
module fpi_align_round
    import fpi_pkg::*;
(
    input  fp_unpacked_t    dec_i,
    input  logic            trunc_i,
    output logic [INT_W:0]  mag_o,
    output logic            lost_o,
    output logic            big_o
);
    localparam int SHIFT_W = $clog2(FIX_W);
    localparam int OFFSET  = INT_W - (SIG_W - 1);

    logic signed [EXP_W-1:0] exp_s;
    logic                    tiny;
    logic [SHIFT_W-1:0]      shamt;
    logic [FIX_W-1:0]        fixed;
    logic [INT_W-1:0]        ipart;
    logic                    rbit;
    logic                    sticky;
    logic                    bump;

    assign exp_s = $signed(dec_i.exp);

    // Place the binary point and collect round and sticky bits.
    always_comb begin
        big_o = exp_s > EXP_W'(INT_W - 1);
        tiny  = exp_s < -EXP_W'(1);
        shamt = SHIFT_W'(exp_s + EXP_W'(OFFSET));
        fixed = FIX_W'(dec_i.sig) << shamt;
        if (tiny) begin
            ipart  = '0;
            rbit   = 1'b0;
            sticky = |dec_i.sig;
        end else begin
            ipart  = fixed[FIX_W-1:INT_W];
            rbit   = fixed[INT_W-1];
            sticky = |fixed[INT_W-2:0];
        end
    end

    // Apply the rounding increment.
    always_comb begin
        bump   = !trunc_i && rbit && (sticky || ipart[0]);
        mag_o  = {1'b0, ipart} + (INT_W+1)'(bump);
        lost_o = rbit || sticky;
    end
endmodule

// File: rtl/fpi_saturate.sv
// Module: turns magnitude and class into the final integer and flags:
// NaN -> all ones, unsigned negative -> 0, out of range -> clamp.
// Assumes mag_i is meaningful only for finite, non-big inputs.
module fpi_saturate
    import fpi_pkg::*;
(
    input  fp_unpacked_t      dec_i,
    input  logic [INT_W:0]    mag_i,
    input  logic              lost_i,
    input  logic              big_i,
    input  logic              dst_64_i,
    input  logic              signed_i,
    output logic [INT_W-1:0]  result_o,
    output logic              invalid_o,
    output logic              inexact_o
);
    logic [INT_W-1:0] wmask;
    logic [INT_W:0]   pos_lim;
    logic [INT_W:0]   neg_lim;
    logic             ovf;

    // Width-dependent limits.
    always_comb begin
        wmask   = dst_64_i ? {INT_W{1'b1}} : INT_W'({NARROW_W{1'b1}});
        pos_lim = signed_i ? {2'b00, wmask[INT_W-1:1]} : {1'b0, wmask};
        if (!dst_64_i)
            pos_lim = signed_i ? (INT_W+1)'({(NARROW_W-1){1'b1}}) : {1'b0, wmask};
        neg_lim = pos_lim + 1'b1;
        ovf     = dec_i.is_inf || big_i;
    end

    // Select result and flags by class, sign and range.
    always_comb begin
        result_o  = '0;
        invalid_o = 1'b0;
        inexact_o = 1'b0;
        if (dec_i.is_nan) begin
            result_o  = wmask;
            invalid_o = 1'b1;
        end else if (!signed_i && dec_i.sign && !dec_i.is_zero) begin
            invalid_o = 1'b1;
        end else if (!dec_i.sign) begin
            if (ovf || mag_i > pos_lim) begin
                result_o  = pos_lim[INT_W-1:0];
                invalid_o = 1'b1;
            end else begin
                result_o  = mag_i[INT_W-1:0];
                inexact_o = lost_i;
            end
        end else begin
            if (ovf || mag_i > neg_lim) begin
                result_o  = neg_lim[INT_W-1:0];
                invalid_o = 1'b1;
            end else begin
                result_o  = (-mag_i[INT_W-1:0]) & wmask;
                inexact_o = lost_i;
            end
        end
    end
endmodule

// File: rtl/fp_to_int_conv.sv
// Module: top of the float-to-integer converter. Decodes both source
// formats, picks one, aligns/rounds, saturates, and registers the result
// one cycle after in_valid. Assumes in_valid is a single-cycle strobe.
module fp_to_int_conv
    import fpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPND_W-1:0] in_operand,
    input  logic              in_is_double,
    input  logic              in_dst_64,
    input  logic              in_signed,
    input  logic              in_trunc,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic [FLAG_W-1:0] out_flags
);
    fp_unpacked_t     dec_dbl;
    fp_unpacked_t     dec_sgl;
    fp_unpacked_t     dec_sel;
    logic [INT_W:0]   mag;
    logic             lost;
    logic             big;
    logic [INT_W-1:0] sat_result;
    logic             sat_invalid;
    logic             sat_inexact;
    logic [FLAG_W-1:0] next_flags;

    fpi_decode #(.EW(DBL_EXP_W), .FW(DBL_FRAC_W)) u_dec_dbl (
        .bits_i (in_operand),
        .dec_o  (dec_dbl)
    );

    fpi_decode #(.EW(SGL_EXP_W), .FW(SGL_FRAC_W)) u_dec_sgl (
        .bits_i (in_operand[SGL_W-1:0]),
        .dec_o  (dec_sgl)
    );

    assign dec_sel = in_is_double ? dec_dbl : dec_sgl;

    fpi_align_round u_align (
        .dec_i   (dec_sel),
        .trunc_i (in_trunc),
        .mag_o   (mag),
        .lost_o  (lost),
        .big_o   (big)
    );

    fpi_saturate u_sat (
        .dec_i     (dec_sel),
        .mag_i     (mag),
        .lost_i    (lost),
        .big_i     (big),
        .dst_64_i  (in_dst_64),
        .signed_i  (in_signed),
        .result_o  (sat_result),
        .invalid_o (sat_invalid),
        .inexact_o (sat_inexact)
    );

    // Pack the two flags into their status positions.
    always_comb begin
        next_flags           = '0;
        next_flags[INV_BIT]  = sat_invalid;
        next_flags[INEX_BIT] = sat_inexact;
    end

    // Output register: capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= sat_result;
                out_flags  <= next_flags;
            end
        end
    end
endmodule

// File: rtl/fpi_conv_checker.sv
// Checker: protocol and special-case properties of fp_to_int_conv, using
// its own decode of the operand class. Bound to the top below.
module fpi_conv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_operand,
    input logic        in_is_double,
    input logic        in_dst_64,
    input logic        in_signed,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic [5:0]  out_flags
);
    logic op_nan;
    logic op_neg_nz;

    // Independent classification of the operand.
    always_comb begin
        if (in_is_double) begin
            op_nan    = (in_operand[62:52] == 11'h7FF) && (in_operand[51:0] != '0);
            op_neg_nz = in_operand[63] && (in_operand[62:0] != '0);
        end else begin
            op_nan    = (in_operand[30:23] == 8'hFF) && (in_operand[22:0] != '0);
            op_neg_nz = in_operand[31] && (in_operand[30:0] != '0);
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_flags)); // R1
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_flags[1] && out_flags[5])); // R4
    AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_signed && !op_nan && op_neg_nz |=> out_result == 64'd0 && out_flags == 6'b000010); // R5
    AST_NAN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nan && in_dst_64 |=> out_result == {64{1'b1}} && out_flags[1]); // R6
    AST_NAN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nan && !in_dst_64 |=> out_result == 64'h0000_0000_FFFF_FFFF && out_flags[1]); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_dst_64 |=> out_result[63:32] == 32'd0); // R8
    AST_UNUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[0] == 1'b0 && out_flags[4:2] == 3'd0); // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> !out_valid && out_result == 64'd0 && out_flags == 6'd0); // R10
endmodule

bind fp_to_int_conv fpi_conv_checker u_fpi_conv_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_operand   (in_operand),
    .in_is_double (in_is_double),
    .in_dst_64    (in_dst_64),
    .in_signed    (in_signed),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_flags    (out_flags)
);

// File: tb/test_fp_to_int_conv.sv
module test_fp_to_int_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        in_is_double = 1'b0;
    logic        in_dst_64 = 1'b0;
    logic        in_signed = 1'b0;
    logic        in_trunc = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [5:0] F_NONE = 6'b000000;
    localparam logic [5:0] F_INV  = 6'b000010;
    localparam logic [5:0] F_INEX = 6'b100000;

    always #10 clk = ~clk;

    fp_to_int_conv i_fp_to_int_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_is_double(in_is_double), .in_dst_64(in_dst_64), .in_signed(in_signed),
        .in_trunc(in_trunc), .out_valid(out_valid), .out_result(out_result),
        .out_flags(out_flags)
    );

    task automatic check(input string tag, input logic [63:0] got_r, input logic [63:0] exp_r,
                         input logic [5:0] got_f, input logic [5:0] exp_f);
        checks++;
        if (got_r !== exp_r || got_f !== exp_f) begin
            failures++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, got_r, got_f, exp_r, exp_f);
        end
    endtask

    // Drive one operand, sample the registered output one cycle later.
    task automatic convert(input logic [63:0] op, input bit dbl, input bit d64,
                           input bit sgn, input bit tr, input string tag,
                           input logic [63:0] exp_r, input logic [5:0] exp_f);
        @(negedge clk);
        in_operand = op; in_is_double = dbl; in_dst_64 = d64;
        in_signed = sgn; in_trunc = tr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R1"}, {63'd0, out_valid}, 64'd1, F_NONE, F_NONE);
        check(tag, out_result, exp_r, out_flags, exp_f);
    endtask

    // Reference: value = +/-(ip + q/4), expected integer and flags.
    function automatic void model(input bit neg, input longint unsigned ip, input int q,
                                  input bit d64, input bit sgn, input bit tr,
                                  output logic [63:0] r, output logic [5:0] f);
        longint unsigned rm, lim, mask;
        bit nz = (ip != 0) || (q != 0);
        rm   = tr ? ip : ip + ((q == 3 || (q == 2 && ip[0])) ? 1 : 0);
        mask = d64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        f = (q != 0) ? F_INEX : F_NONE;
        if (!sgn) begin
            if (neg && nz) begin r = 0; f = F_INV; end
            else if (rm > mask) begin r = mask; f = F_INV; end
            else r = rm;
        end else begin
            lim = mask >> 1;
            if (!neg && rm > lim) begin r = lim; f = F_INV; end
            else if (neg && rm > lim + 1) begin r = lim + 1; f = F_INV; end
            else r = neg ? ((-rm) & mask) : rm;
        end
    endfunction

    function automatic logic [63:0] encode(input bit neg, input longint unsigned ip,
                                           input int q, input bit dbl);
        real v;
        logic [63:0] d;
        v = real'(ip) + real'(q) / 4.0;
        if (neg) v = -v;
        d = $realtobits(v);
        if (dbl) return d;
        if (d[62:52] == 11'd0) return {32'd0, d[63], 31'd0};
        return {32'd0, d[63], 8'(d[62:52] - 11'd1023 + 11'd127), d[51:29]};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: result=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] er;
        logic [5:0]  ef;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("reset R10", {63'd0, out_valid} | out_result, 64'd0, out_flags, F_NONE);
        rst_n = 1'b1;

        // Rounding and truncation
        convert(64'h40200000, 0, 0, 1, 0, "2.5 nearest R2", 64'd2, F_INEX);
        convert(64'h40600000, 0, 0, 1, 0, "3.5 nearest R2", 64'd4, F_INEX);
        convert(64'hC004000000000000, 1, 1, 1, 0, "-2.5 nearest R2", 64'hFFFF_FFFF_FFFF_FFFE, F_INEX);
        convert(64'hC004000000000000, 1, 0, 1, 1, "-2.5 trunc R3", 64'h0000_0000_FFFF_FFFE, F_INEX);
        convert(64'h3F400000, 0, 0, 0, 1, "0.75 trunc R3", 64'd0, F_INEX);
        convert(64'h3F400000, 0, 0, 0, 0, "0.75 nearest R2", 64'd1, F_INEX);
        convert(64'h3F000000, 0, 1, 1, 0, "0.5 tie R2", 64'd0, F_INEX);
        convert(64'h00000001, 0, 1, 1, 0, "denormal R4", 64'd0, F_INEX);
        // Unsigned negative rule
        convert(64'hAB98FBA8, 0, 0, 0, 0, "tiny neg u32 R5", 64'd0, F_INV);
        convert(64'hAB98FBA8, 0, 1, 0, 1, "tiny neg u64 trunc R5", 64'd0, F_INV);
        convert(64'hBD731F7500000000, 1, 1, 0, 0, "dbl tiny neg u64 R5", 64'd0, F_INV);
        convert(64'hBD731F7500000000, 1, 0, 0, 1, "dbl tiny neg u32 trunc R5", 64'd0, F_INV);
        convert(64'h80000000, 0, 0, 0, 0, "neg zero R5", 64'd0, F_NONE);
        // NaN
        convert(64'h7FC00000, 0, 0, 1, 0, "sgl nan s32 R6", 64'h0000_0000_FFFF_FFFF, F_INV);
        convert(64'h7FC00000, 0, 1, 1, 1, "sgl nan s64 trunc R6", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        convert(64'h7FF8000000000000, 1, 0, 1, 1, "dbl qnan s32 R6", 64'h0000_0000_FFFF_FFFF, F_INV);
        convert(64'h7FF7000000000000, 1, 1, 1, 0, "dbl snan s64 R6", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        convert(64'h7FF8000000000000, 1, 1, 0, 0, "dbl nan u64 R6", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        // Saturation and endpoints
        convert(64'h7F800000, 0, 0, 1, 0, "+inf s32 R7", 64'h0000_0000_7FFF_FFFF, F_INV);
        convert(64'hFFF0000000000000, 1, 1, 1, 0, "-inf s64 R7", 64'h8000_0000_0000_0000, F_INV);
        convert(64'h7F800000, 0, 1, 0, 0, "+inf u64 R7", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        convert(64'h43E0000000000000, 1, 1, 1, 0, "2^63 s64 R7", 64'h7FFF_FFFF_FFFF_FFFF, F_INV);
        convert(64'hC3E0000000000000, 1, 1, 1, 0, "-2^63 s64 R7", 64'h8000_0000_0000_0000, F_NONE);
        convert(64'h43E0000000000000, 1, 1, 0, 0, "2^63 u64 R7", 64'h8000_0000_0000_0000, F_NONE);
        convert(64'h43F0000000000000, 1, 1, 0, 0, "2^64 u64 R7", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        convert(64'h4F000000, 0, 0, 1, 0, "2^31 s32 R7", 64'h0000_0000_7FFF_FFFF, F_INV);
        convert(64'hCF000000, 0, 0, 1, 1, "-2^31 s32 R7", 64'h0000_0000_8000_0000, F_NONE);
        // Upper bits ignored for binary32
        convert(64'hDEADBEEF_40200000, 0, 0, 1, 0, "upper ignored R9", 64'd2, F_INEX);
        // Hold and idle strobe
        @(negedge clk);
        check("idle valid R1", {63'd0, out_valid}, 64'd0, F_NONE, F_NONE);
        check("hold R1", out_result, 64'd2, out_flags, F_INEX);

        // Random stimulus
        for (int i = 0; i < 600; i++) begin
            bit dbl = 1'($urandom);
            bit d64 = 1'($urandom);
            bit sgn = 1'($urandom);
            bit tr  = 1'($urandom);
            bit neg = 1'($urandom);
            int q   = int'($urandom % 4);
            longint unsigned ip;
            if (dbl) ip = {$urandom, $urandom} >> (24 + ($urandom % 40));
            else     ip = 64'($urandom >> (11 + ($urandom % 21)));
            model(neg, ip, q, d64, sgn, tr, er, ef);
            if (d64) er = er; else er[63:32] = 32'd0;
            convert(encode(neg, ip, q, dbl), dbl, d64, sgn, tr,
                    tr ? "random R3" : "random R2", er, ef);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule